// File: doc/BRIEF.md
# Grouped Four-Level Interrupt Priority Controller

This block sits between a set of interrupt pending flags and a small 8-bit CPU core. It chooses which pending source to hand to the CPU. Every source belongs to one of six priority groups, and source `s` falls in group `s mod 6`. Each group takes one of four levels. The level is a 2-bit number: its high bit comes from one 8-bit configuration register and its low bit from a second register, both at bit position `g` for group `g`.

A source competes for service only when its pending flag, its own enable and the global enable are all set. Among the competitors, the highest level wins, and a tie at the same level goes to the lowest source index. A winner is offered to the CPU only when its level is strictly above every level now in service. The offer is a registered request with an index and a level, and it stays unchanged until the CPU acknowledges it. The acknowledge marks that level as in service. A return-from-interrupt pulse retires the highest level in service.

Top module: `irqp_ctrl`

## Requirements
- R1: After reset, both priority registers read 0, `vec_req` is 0 and `in_svc` is 0.
- R2: A write with `cfg_sel`=0 loads the low-bit register and with `cfg_sel`=1 the high-bit register, from `cfg_wdata[5:0]`. Bits 7:6 of both read values are always 0.
- R3: Source `s` has level `{prio_hi[s mod 6], prio_lo[s mod 6]}`, where 3 is the highest. The competing source with the highest level is the one offered.
- R4: Among competing sources of equal level, the lowest source index is offered.
- R5: A source competes only when `src_pend[s]`, `src_en[s]` and `glob_en` are all 1.
- R6: While `vec_req` is 1 and `vec_ack` is 0, `vec_req`, `vec_idx` and `vec_lvl` hold their values, even if a higher-level source becomes pending.
- R7: A clock edge with `vec_ack`=1 and `vec_req`=1 sets `in_svc[vec_lvl]` and drops `vec_req`.
- R8: A winner is offered only when its level is strictly greater than the highest set bit of `in_svc`, or when `in_svc` is 0. Equal or lower levels wait.
- R9: A clock edge with `reti`=1 clears the highest set bit of `in_svc`. With `in_svc`=0 it has no effect.
- R10: With `vec_req` at 0, an eligible winner raises `vec_req` at the first clock edge after it appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Priority register write strobe |
| cfg_sel | input | 1 | 0: low-bit register, 1: high-bit register |
| cfg_wdata | input | 8 | Write data; bit g belongs to group g |
| prio_lo | output | 8 | Read value of the low-bit register |
| prio_hi | output | 8 | Read value of the high-bit register |
| src_pend | input | NUM_SRC | Pending flag per source |
| src_en | input | NUM_SRC | Individual enable per source |
| glob_en | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | CPU accepts the offered vector |
| reti | input | 1 | CPU return-from-interrupt pulse |
| vec_req | output | 1 | Vector request to the CPU |
| vec_idx | output | IDX_W | Index of the offered source |
| vec_lvl | output | 2 | Level of the offered source |
| in_svc | output | 4 | In-service mask, one bit per level |

## Verification
The embedded assertions check four properties on every cycle. A held request does not change (R6). An acknowledge sets the granted level's bit (R7). An offered request always sits above the in-service ceiling (R8). A return retires exactly one level (R9). They also check that register writes land (R2) and that requests rise only under the global enable (R5). Which source actually wins needs the bench's scenarios: group mapping by modulo, tie-breaking by index, and the order in which waiting sources appear as levels are retired (R3, R4, R10). The scoreboard compares each offered index and level against those scenarios.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

    localparam int NUM_GRP = 6;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int REG_W   = 8;

    typedef logic [LVL_W-1:0]   lvl_t;
    typedef logic [NUM_LVL-1:0] lvl_mask_t;

    typedef struct packed {
        logic [NUM_GRP-1:0] hi;
        logic [NUM_GRP-1:0] lo;
    } prio_cfg_t;

    typedef struct packed {
        logic valid;
        lvl_t lvl;
    } ceil_t;

    // Highest set level in a mask, with a flag for an empty mask.
    function automatic ceil_t top_level(lvl_mask_t m);
        ceil_t r;
        r = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            if (m[l]) begin
                r.valid = 1'b1;
                r.lvl   = lvl_t'(l);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irqp_prio_regs.sv
module irqp_prio_regs
    import irqp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output prio_cfg_t        cfg,
    output logic [REG_W-1:0] rd_lo,
    output logic [REG_W-1:0] rd_hi
);
    localparam int PAD_W = REG_W - NUM_GRP;

    prio_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (we) begin
            if (sel) cfg_q.hi <= wdata[NUM_GRP-1:0];
            else     cfg_q.lo <= wdata[NUM_GRP-1:0];
        end
    end

    assign cfg   = cfg_q;
    assign rd_lo = {{PAD_W{1'b0}}, cfg_q.lo};
    assign rd_hi = {{PAD_W{1'b0}}, cfg_q.hi};

    a_r2_low_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && !sel) |=> (rd_lo[NUM_GRP-1:0] == $past(wdata[NUM_GRP-1:0])));

    a_r2_high_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && sel) |=> (rd_hi[NUM_GRP-1:0] == $past(wdata[NUM_GRP-1:0])));

endmodule

// File: rtl/irqp_arbiter.sv
module irqp_arbiter
    import irqp_pkg::*;
#(
    parameter int NUM_SRC = 18,
    parameter int IDX_W   = $clog2(NUM_SRC)
)(
    input  logic [NUM_SRC-1:0] cand,
    input  prio_cfg_t          cfg,
    input  ceil_t              ceil,
    output logic               elig,
    output logic [IDX_W-1:0]   win_idx,
    output lvl_t               win_lvl
);
    lvl_t src_lvl [NUM_SRC];
    logic win_valid;

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_map
        localparam int GRP = s % NUM_GRP;
        assign src_lvl[s] = {cfg.hi[GRP], cfg.lo[GRP]};
    end

    // Ascending level, descending index: the last hit is the highest
    // level and, within it, the lowest index.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        win_lvl   = '0;
        for (int l = 0; l < NUM_LVL; l++) begin
            for (int s = NUM_SRC - 1; s >= 0; s--) begin
                if (cand[s] && src_lvl[s] == lvl_t'(l)) begin
                    win_valid = 1'b1;
                    win_idx   = IDX_W'(s);
                    win_lvl   = lvl_t'(l);
                end
            end
        end
    end

    assign elig = win_valid && (!ceil.valid || (win_lvl > ceil.lvl));

endmodule

// File: rtl/irqp_nest.sv
module irqp_nest
    import irqp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ack,
    input  lvl_t      ack_lvl,
    input  logic      reti,
    output lvl_mask_t svc,
    output ceil_t     ceil
);
    lvl_mask_t svc_q, svc_d;

    assign ceil = top_level(svc_q);

    always_comb begin
        svc_d = svc_q;
        if (reti && ceil.valid) svc_d[ceil.lvl] = 1'b0;
        if (ack) svc_d[ack_lvl] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) svc_q <= '0;
        else     svc_q <= svc_d;
    end

    assign svc = svc_q;

    a_r7_ack_marks_level: assert property (@(posedge clk) disable iff (rst)
        ack |=> svc_q[$past(ack_lvl)]);

    a_r9_reti_retires_one: assert property (@(posedge clk) disable iff (rst)
        (reti && !ack && (svc_q != '0)) |=>
            ($countones(svc_q) == $countones($past(svc_q)) - 1));

endmodule

// File: rtl/irqp_ctrl.sv
module irqp_ctrl
    import irqp_pkg::*;
#(
    parameter int NUM_SRC = 18,
    parameter int IDX_W   = $clog2(NUM_SRC)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_we,
    input  logic               cfg_sel,
    input  logic [REG_W-1:0]   cfg_wdata,
    output logic [REG_W-1:0]   prio_lo,
    output logic [REG_W-1:0]   prio_hi,
    input  logic [NUM_SRC-1:0] src_pend,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               glob_en,
    input  logic               vec_ack,
    input  logic               reti,
    output logic               vec_req,
    output logic [IDX_W-1:0]   vec_idx,
    output logic [LVL_W-1:0]   vec_lvl,
    output logic [NUM_LVL-1:0] in_svc
);
    prio_cfg_t          cfg;
    ceil_t              ceil;
    lvl_mask_t          svc;
    logic [NUM_SRC-1:0] cand;
    logic               elig;
    logic [IDX_W-1:0]   win_idx;
    lvl_t               win_lvl;
    logic               req_q;
    logic [IDX_W-1:0]   idx_q;
    lvl_t               lvl_q;
    logic               take;

    irqp_prio_regs u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .cfg(cfg), .rd_lo(prio_lo), .rd_hi(prio_hi)
    );

    assign cand = src_pend & src_en & {NUM_SRC{glob_en}};

    irqp_arbiter #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_arb (
        .cand(cand), .cfg(cfg), .ceil(ceil),
        .elig(elig), .win_idx(win_idx), .win_lvl(win_lvl)
    );

    assign take = req_q && vec_ack;

    irqp_nest u_nest (
        .clk(clk), .rst(rst), .ack(take), .ack_lvl(lvl_q), .reti(reti),
        .svc(svc), .ceil(ceil)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= 1'b0;
            idx_q <= '0;
            lvl_q <= '0;
        end else if (req_q) begin
            if (vec_ack) req_q <= 1'b0;
        end else if (elig) begin
            req_q <= 1'b1;
            idx_q <= win_idx;
            lvl_q <= win_lvl;
        end
    end

    assign vec_req = req_q;
    assign vec_idx = idx_q;
    assign vec_lvl = lvl_q;
    assign in_svc  = svc;

    a_r6_offer_holds: assert property (@(posedge clk) disable iff (rst)
        (vec_req && !vec_ack) |=>
            (vec_req && $stable(vec_idx) && $stable(vec_lvl)));

    a_r8_offer_above_ceiling: assert property (@(posedge clk) disable iff (rst)
        vec_req |-> ((in_svc & ~((NUM_LVL'(1) << vec_lvl) - NUM_LVL'(1))) == '0));

    a_r5_rise_needs_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(vec_req) |-> $past(glob_en));

endmodule

// File: tb/irqp_ctrl_test.sv
module irqp_ctrl_test;
    localparam int NS = 18;
    localparam int IW = $clog2(NS);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]    cfg_wdata = '0;
    logic [7:0]    prio_lo, prio_hi;
    logic [NS-1:0] src_pend = '0, src_en = '0;
    logic          glob_en = 1'b0, vec_ack = 1'b0, reti = 1'b0;
    logic          vec_req;
    logic [IW-1:0] vec_idx;
    logic [1:0]    vec_lvl;
    logic [3:0]    in_svc;

    int errors = 0;
    int checks = 0;
    int    q_idx[$];
    int    q_lvl[$];
    string q_tag[$];
    logic  prev_req = 1'b0;

    always #4 clk = ~clk;

    irqp_ctrl #(.NUM_SRC(NS)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .prio_lo(prio_lo), .prio_hi(prio_hi),
        .src_pend(src_pend), .src_en(src_en), .glob_en(glob_en),
        .vec_ack(vec_ack), .reti(reti), .vec_req(vec_req),
        .vec_idx(vec_idx), .vec_lvl(vec_lvl), .in_svc(in_svc)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_grant(input int idx, input int lvl, input string tag);
        q_idx.push_back(idx);
        q_lvl.push_back(lvl);
        q_tag.push_back(tag);
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); vec_ack = 1'b1;
        @(negedge clk); vec_ack = 1'b0;
    endtask

    task automatic do_reti();
        @(negedge clk); reti = 1'b1;
        @(negedge clk); reti = 1'b0;
    endtask

    // Monitor: each new request is matched against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst && vec_req && !prev_req) begin
            if (q_idx.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R8 unexpected request actual=%0d expected=none", vec_idx);
            end else begin
                automatic int    ei = q_idx.pop_front();
                automatic int    el = q_lvl.pop_front();
                automatic string et = q_tag.pop_front();
                chk(int'(vec_idx) == ei, {et, " index"}, int'(vec_idx), ei);
                chk(int'(vec_lvl) == el, {et, " level"}, int'(vec_lvl), el);
            end
        end
        prev_req = rst ? 1'b0 : vec_req;
    end

    task automatic run();
        cyc(3);
        rst = 1'b0;
        cyc(1);
        chk(vec_req == 1'b0, "R1 no request", vec_req, 0);
        chk(in_svc == 4'd0, "R1 in_svc", in_svc, 0);
        chk(prio_lo == 8'd0 && prio_hi == 8'd0, "R1 prio regs", {prio_hi, prio_lo}, 0);

        wr(1'b0, 8'hFF);
        chk(prio_lo == 8'h3F, "R2 low reg unused bits", prio_lo, 8'h3F);
        wr(1'b1, 8'hC5);
        chk(prio_hi == 8'h05, "R2 high reg unused bits", prio_hi, 8'h05);
        // group1 -> level 3, group2 -> level 2, others level 0
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h06);
        chk(prio_lo == 8'h02 && prio_hi == 8'h06, "R2 config", {prio_hi, prio_lo}, 16'h0602);

        @(negedge clk); glob_en = 1'b1; src_pend[0] = 1'b1;
        cyc(3);
        chk(vec_req == 1'b0, "R5 source enable off", vec_req, 0);
        @(negedge clk); src_en = '1; glob_en = 1'b0;
        cyc(3);
        chk(vec_req == 1'b0, "R5 global enable off", vec_req, 0);
        @(negedge clk); src_pend[0] = 1'b0; glob_en = 1'b1;
        cyc(2);

        expect_grant(6, 0, "R4 lowest index at equal level");
        @(negedge clk); src_pend[6] = 1'b1; src_pend[12] = 1'b1;
        @(negedge clk);
        chk(vec_req == 1'b1, "R10 request one edge later", vec_req, 1);
        cyc(3);
        chk(int'(vec_idx) == 6, "R6 held until ack", vec_idx, 6);
        ack();
        chk(in_svc == 4'b0001, "R7 level0 in service", in_svc, 1);
        chk(vec_req == 1'b0, "R7 request dropped", vec_req, 0);
        cyc(3);
        chk(vec_req == 1'b0, "R8 equal level waits", vec_req, 0);

        expect_grant(2, 2, "R3 group2 at level2");
        @(negedge clk); src_pend[2] = 1'b1;
        @(negedge clk); src_pend[1] = 1'b1;
        cyc(3);
        chk(int'(vec_idx) == 2 && vec_lvl == 2'd2, "R6 held despite higher", vec_idx, 2);
        expect_grant(1, 3, "R8 higher level nests");
        ack();
        chk(in_svc == 4'b0101, "R7 level2 in service", in_svc, 5);
        cyc(1);
        ack();
        chk(in_svc == 4'b1101, "R7 level3 in service", in_svc, 13);
        @(negedge clk); src_pend[1] = 1'b0; src_pend[2] = 1'b0;
        src_pend[13] = 1'b1; src_pend[8] = 1'b1;
        cyc(2);
        chk(vec_req == 1'b0, "R8 blocked below ceiling", vec_req, 0);

        expect_grant(13, 3, "R3 group by modulo");
        do_reti();
        chk(in_svc == 4'b0101, "R9 retire level3", in_svc, 5);
        cyc(1);
        ack();
        @(negedge clk); src_pend[13] = 1'b0;
        do_reti();
        chk(in_svc == 4'b0101, "R9 retire nested level3", in_svc, 5);
        expect_grant(8, 2, "R3 source8 at level2");
        do_reti();
        chk(in_svc == 4'b0001, "R9 retire level2", in_svc, 1);
        cyc(1);
        ack();
        @(negedge clk); src_pend[8] = 1'b0;
        do_reti();
        chk(in_svc == 4'b0001, "R9 back to level0", in_svc, 1);
        expect_grant(6, 0, "R4 source6 after retire");
        do_reti();
        cyc(1);
        ack();
        @(negedge clk); src_pend[6] = 1'b0;
        expect_grant(12, 0, "R4 source12 last");
        do_reti();
        cyc(1);
        ack();
        @(negedge clk); src_pend[12] = 1'b0;
        do_reti();
        chk(in_svc == 4'b0000, "R9 all retired", in_svc, 0);
        do_reti();
        chk(in_svc == 4'b0000, "R9 retire on empty mask", in_svc, 0);
        cyc(2);
        chk(q_idx.size() == 0, "R10 every expected grant seen", q_idx.size(), 0);
    endtask

    initial begin
        fork
            run();
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule